// File: doc/BRIEF.md
# PCI Target Configuration and Decode

This block is the back-end logic that sits behind a PCI target core. It sees the core's registered address/data bus and its command/byte-enable nibble. In the single cycle when the core flags the address as valid, the block classifies the command as read, write or configuration intent. In that same cycle it compares the address against its base address registers (BARs), and it returns the decode and hit responses at once. It also captures the address and the kind of transaction, because later cycles carry data instead.

While the burst runs, the block steps its own copy of the address by 4 on every increment pulse. It gives the back end one write strobe per dword for user writes and a separate one for configuration writes. It holds a small type-0 header: the command bits, three sticky error status bits, the cache line size, the latency timer and a parameterised set of memory and I/O BARs. It serves configuration reads from that header and exports the command and timing fields as control outputs. The core sends error pulses, which set the status bits. Software clears them by writing ones.

Top module: `pci_tgt_cfg_decode`

## Requirements
- R1: In a cycle with `tgt_addr_vld` high, `tgt_ad` is captured and appears on `burst_addr` from the next cycle onward.
- R2: In a cycle with `tgt_addr_inc` high and `tgt_addr_vld` low, `burst_addr` advances by 4 at the next edge; otherwise it holds.
- R3: `dec_hit` is high only while `tgt_addr_vld` is high. For a memory command (0110, 0111, 1100, 1110, 1111) it needs an address inside a memory BAR with command bit 1 set. For an I/O command (0010, 0011) it needs an address inside an I/O BAR with command bit 0 set. Default BARs: BAR0 is memory with a 4 KiB window; BAR1 is I/O with a 32-byte window.
- R4: While `tgt_addr_vld` is high, `dec_rd` is high for commands 0010, 0110, 1100 and 1110, and `dec_wr` is high for commands 0011, 0111 and 1111. Configuration commands 1010 and 1011, and all other codes, raise neither output.
- R5: `usr_wr_stb` is high in exactly the cycles where `tgt_addr_inc` is high and the last address cycle was a write command that hit. `cfg_wr_stb` is high in exactly the increment cycles whose last address cycle was command 1011 with `tgt_idsel` high. Neither output depends on any ready signal.
- R6: `cfg_rd_data` returns the header dword selected by `burst_addr[7:2]`. The indices are: 1 for command/status, 3 for cache line/latency, and 4 plus n for BAR n. Every other index reads zero.
- R7: The command register stores only bits 0, 1, 3, 4, 6 and 8; all other command bits read zero. Bits 3, 4, 6 and 8 drive `ctl_special_en`, `ctl_mwi_en`, `ctl_par_resp` and `ctl_serr_en`.
- R8: Pulses on `ev_par_err`, `ev_sys_err` and `ev_mst_par_err` set status bits 15, 14 and 8, which read at dword bits 31, 30 and 24 of index 1. Each bit stays set until it is cleared.
- R9: A configuration write to index 1 with byte 3 enabled clears each status bit written as 1. A set pulse in the same cycle wins over the clear.
- R10: Byte 0 of index 3 stores cache line size bits [7:2], and bits [1:0] read 00. Byte 1 of index 3 is the 8-bit latency timer. Both drive `ctl_cache_line` and `ctl_lat_timer`.
- R11: A BAR stores only the address bits at or above its size. Its lower bits read zero, except that bit 0 of an I/O BAR reads 1, so writing all ones reads back the size mask.
- R12: Configuration writes update only bytes whose byte enable (`tgt_cbe` during the data cycle, active low, bit n for byte n) is 0.
- R13: After reset, all header registers and `burst_addr` are zero, and no strobe or decode output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_ad | input | 32 | Address in the address cycle, write data in data cycles |
| tgt_cbe | input | 4 | Command in the address cycle, active-low byte enables afterwards |
| tgt_addr_vld | input | 1 | Address cycle pulse |
| tgt_addr_inc | input | 1 | Data transfer completed; advance the address |
| tgt_idsel | input | 1 | Configuration select for this device |
| ev_par_err | input | 1 | Detected parity error pulse |
| ev_sys_err | input | 1 | Signaled system error pulse |
| ev_mst_par_err | input | 1 | Master data parity error pulse |
| dec_rd | output | 1 | Read command decoded in the address cycle |
| dec_wr | output | 1 | Write command decoded in the address cycle |
| dec_hit | output | 1 | Address inside an enabled BAR of matching space |
| burst_addr | output | 32 | Captured and self-incremented burst address |
| usr_wr_stb | output | 1 | Per-dword user write strobe |
| cfg_wr_stb | output | 1 | Per-dword configuration write strobe |
| cfg_rd_data | output | 32 | Configuration header read data |
| ctl_special_en | output | 1 | Command bit 3 |
| ctl_mwi_en | output | 1 | Command bit 4 |
| ctl_par_resp | output | 1 | Command bit 6 |
| ctl_serr_en | output | 1 | Command bit 8 |
| ctl_lat_timer | output | 8 | Latency timer |
| ctl_cache_line | output | 6 | Cache line size bits [7:2] |

## Verification
A wrong captured address or a missed increment shows on `burst_addr` in the very next cycle. It also moves `cfg_rd_data` to another header index. A wrong stored transaction kind shows up only on the first increment pulse, as a missing or extra strobe. A corrupted header register shows in two ways. It changes `dec_hit` on the next address cycle, or it shows on the control outputs at once and on `cfg_rd_data` as soon as that index is read. The bench compares every output each cycle against its own model. That way, a fault shows at the first cycle where it is visible rather than at a later readback.

// File: rtl/pcitd_pkg.sv
package pcitd_pkg;

  typedef enum logic [2:0] {
    TX_NONE   = 3'd0,
    TX_USR_RD = 3'd1,
    TX_USR_WR = 3'd2,
    TX_CFG_RD = 3'd3,
    TX_CFG_WR = 3'd4
  } txn_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic cfg_rd;
    logic cfg_wr;
    logic io;
    logic mem;
  } cmd_class_t;

  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_IO_WR   = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
  localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
  localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
  localparam logic [3:0] CMD_MEM_WI  = 4'b1111;

  localparam int          IDX_W       = 6;
  localparam logic [5:0]  IDX_CMDSTAT = 6'd1;
  localparam logic [5:0]  IDX_MISC    = 6'd3;
  localparam logic [5:0]  IDX_BAR0    = 6'd4;

  localparam logic [7:0]  CMD_LO_KEEP = 8'h5B;

endpackage

// File: rtl/pcitd_cmd_decode.sv
module pcitd_cmd_decode
  import pcitd_pkg::*;
(
  input  logic [3:0] cmd,
  output cmd_class_t cls
);

  always_comb begin
    cls = '0;
    unique case (cmd)
      CMD_IO_RD:   begin cls.rd = 1'b1; cls.io  = 1'b1; end
      CMD_IO_WR:   begin cls.wr = 1'b1; cls.io  = 1'b1; end
      CMD_MEM_RD,
      CMD_MEM_RDM,
      CMD_MEM_RDL: begin cls.rd = 1'b1; cls.mem = 1'b1; end
      CMD_MEM_WR,
      CMD_MEM_WI:  begin cls.wr = 1'b1; cls.mem = 1'b1; end
      CMD_CFG_RD:  cls.cfg_rd = 1'b1;
      CMD_CFG_WR:  cls.cfg_wr = 1'b1;
      default:     cls = '0;
    endcase
  end

endmodule

// File: rtl/pcitd_bar_match.sv
module pcitd_bar_match #(
  parameter int                  NUM_BARS      = 2,
  parameter logic [NUM_BARS*8-1:0] BAR_SIZE_LOG2 = {8'd5, 8'd12},
  parameter logic [NUM_BARS-1:0] BAR_IO_MASK   = 2'b10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [31:0]            addr,
  input  logic                   is_mem,
  input  logic                   is_io,
  input  logic                   mem_en,
  input  logic                   io_en,
  input  logic [NUM_BARS*32-1:0] bars,
  output logic                   hit
);

  logic [NUM_BARS-1:0] hit_vec;

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    localparam int          SZ   = int'(BAR_SIZE_LOG2[g*8 +: 8]);
    localparam logic [31:0] MASK = ~((32'd1 << SZ) - 32'd1);
    logic in_win;
    assign in_win = (((addr ^ bars[g*32 +: 32]) & MASK) == 32'd0);
    if (BAR_IO_MASK[g]) begin : g_io
      assign hit_vec[g] = in_win & is_io & io_en;
    end else begin : g_mem
      assign hit_vec[g] = in_win & is_mem & mem_en;
    end
  end

  assign hit = |hit_vec;

  // R3: a hit needs the matching space enable from the command register
  a_r3_hit_gated: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((is_mem && mem_en) || (is_io && io_en)));

endmodule

// File: rtl/pcitd_cfg_space.sv
module pcitd_cfg_space
  import pcitd_pkg::*;
#(
  parameter int                    NUM_BARS      = 2,
  parameter logic [NUM_BARS*8-1:0] BAR_SIZE_LOG2 = {8'd5, 8'd12},
  parameter logic [NUM_BARS-1:0]   BAR_IO_MASK   = 2'b10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_stb,
  input  logic [IDX_W-1:0]       idx,
  input  logic [31:0]            wr_data,
  input  logic [3:0]             wr_be_n,
  input  logic                   ev_par_err,
  input  logic                   ev_sys_err,
  input  logic                   ev_mst_par_err,
  output logic [31:0]            rd_data,
  output logic                   io_en,
  output logic                   mem_en,
  output logic                   special_en,
  output logic                   mwi_en,
  output logic                   par_resp,
  output logic                   serr_en,
  output logic [7:0]             lat_timer,
  output logic [5:0]             cache_line,
  output logic [NUM_BARS*32-1:0] bars
);

  logic [7:0]  cmd_lo_q;
  logic        cmd8_q;
  logic [2:0]  stat_q;      // {bit15, bit14, bit8}
  logic [5:0]  cls_q;
  logic [7:0]  lat_q;
  logic [2:0]  w1c;
  logic [2:0]  stat_set;
  logic        wr_cmd, wr_misc;
  logic [31:0] bar_rd [NUM_BARS];

  assign wr_cmd   = wr_stb && (idx == IDX_CMDSTAT);
  assign wr_misc  = wr_stb && (idx == IDX_MISC);
  assign w1c      = (wr_cmd && !wr_be_n[3]) ? {wr_data[31], wr_data[30], wr_data[24]} : 3'b000;
  assign stat_set = {ev_par_err, ev_sys_err, ev_mst_par_err};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_lo_q <= '0;
      cmd8_q   <= 1'b0;
      stat_q   <= '0;
      cls_q    <= '0;
      lat_q    <= '0;
    end else begin
      if (wr_cmd && !wr_be_n[0]) cmd_lo_q <= wr_data[7:0] & CMD_LO_KEEP;
      if (wr_cmd && !wr_be_n[1]) cmd8_q   <= wr_data[8];
      if (wr_misc && !wr_be_n[0]) cls_q   <= wr_data[7:2];
      if (wr_misc && !wr_be_n[1]) lat_q   <= wr_data[15:8];
      stat_q <= (stat_q & ~w1c) | stat_set;
    end
  end

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    localparam int          SZ   = int'(BAR_SIZE_LOG2[g*8 +: 8]);
    localparam logic [31:0] MASK = ~((32'd1 << SZ) - 32'd1);
    localparam logic [5:0]  MY_IDX = IDX_BAR0 + 6'(g);
    logic [31:0] bar_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        bar_q <= '0;
      end else if (wr_stb && idx == MY_IDX) begin
        for (int b = 0; b < 4; b++) begin
          if (!wr_be_n[b]) bar_q[b*8 +: 8] <= wr_data[b*8 +: 8] & MASK[b*8 +: 8];
        end
      end
    end

    assign bars[g*32 +: 32] = bar_q;
    assign bar_rd[g] = bar_q | {31'd0, BAR_IO_MASK[g]};

    // R11: bits below the window size never become set
    a_r11_bar_low_zero: assert property (@(posedge clk) disable iff (rst)
      (bar_q & ~MASK) == 32'd0);
  end

  always_comb begin
    rd_data = '0;
    if (idx == IDX_CMDSTAT) begin
      rd_data = {stat_q[2], stat_q[1], 5'd0, stat_q[0], 15'd0, cmd8_q, cmd_lo_q};
    end else if (idx == IDX_MISC) begin
      rd_data = {16'd0, lat_q, cls_q, 2'b00};
    end else begin
      for (int g = 0; g < NUM_BARS; g++) begin
        if (idx == IDX_BAR0 + 6'(g)) rd_data = bar_rd[g];
      end
    end
  end

  assign io_en      = cmd_lo_q[0];
  assign mem_en     = cmd_lo_q[1];
  assign special_en = cmd_lo_q[3];
  assign mwi_en     = cmd_lo_q[4];
  assign par_resp   = cmd_lo_q[6];
  assign serr_en    = cmd8_q;
  assign lat_timer  = lat_q;
  assign cache_line = cls_q;

  // R8: an error pulse leaves its status bit set after the edge
  a_r8_par_err_sets: assert property (@(posedge clk) disable iff (rst)
    ev_par_err |=> stat_q[2]);
  a_r8_mst_err_sets: assert property (@(posedge clk) disable iff (rst)
    ev_mst_par_err |=> stat_q[0]);
  // R9: a one written without a simultaneous set clears the bit
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (w1c[1] && !ev_sys_err) |=> !stat_q[1]);
  // R10: low cache line bits always read zero
  a_r10_cls_low: assert property (@(posedge clk) disable iff (rst)
    (idx == IDX_MISC) |-> (rd_data[1:0] == 2'b00));

endmodule

// File: rtl/pci_tgt_cfg_decode.sv
module pci_tgt_cfg_decode
  import pcitd_pkg::*;
#(
  parameter int                    NUM_BARS      = 2,
  parameter logic [NUM_BARS*8-1:0] BAR_SIZE_LOG2 = {8'd5, 8'd12},
  parameter logic [NUM_BARS-1:0]   BAR_IO_MASK   = 2'b10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] tgt_ad,
  input  logic [3:0]  tgt_cbe,
  input  logic        tgt_addr_vld,
  input  logic        tgt_addr_inc,
  input  logic        tgt_idsel,
  input  logic        ev_par_err,
  input  logic        ev_sys_err,
  input  logic        ev_mst_par_err,
  output logic        dec_rd,
  output logic        dec_wr,
  output logic        dec_hit,
  output logic [31:0] burst_addr,
  output logic        usr_wr_stb,
  output logic        cfg_wr_stb,
  output logic [31:0] cfg_rd_data,
  output logic        ctl_special_en,
  output logic        ctl_mwi_en,
  output logic        ctl_par_resp,
  output logic        ctl_serr_en,
  output logic [7:0]  ctl_lat_timer,
  output logic [5:0]  ctl_cache_line
);

  localparam int BARS_W = NUM_BARS * 32;

  cmd_class_t        cls;
  logic              mem_en, io_en, bar_hit;
  logic [BARS_W-1:0] bars;
  logic [31:0]       addr_q;
  txn_e              txn_q, txn_d;

  pcitd_cmd_decode u_dec (
    .cmd (tgt_cbe),
    .cls (cls)
  );

  pcitd_bar_match #(
    .NUM_BARS      (NUM_BARS),
    .BAR_SIZE_LOG2 (BAR_SIZE_LOG2),
    .BAR_IO_MASK   (BAR_IO_MASK)
  ) u_match (
    .clk    (clk),
    .rst    (rst),
    .addr   (tgt_ad),
    .is_mem (cls.mem),
    .is_io  (cls.io),
    .mem_en (mem_en),
    .io_en  (io_en),
    .bars   (bars),
    .hit    (bar_hit)
  );

  always_comb begin
    txn_d = TX_NONE;
    if (cls.cfg_rd && tgt_idsel)      txn_d = TX_CFG_RD;
    else if (cls.cfg_wr && tgt_idsel) txn_d = TX_CFG_WR;
    else if (bar_hit && cls.rd)       txn_d = TX_USR_RD;
    else if (bar_hit && cls.wr)       txn_d = TX_USR_WR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      txn_q  <= TX_NONE;
    end else if (tgt_addr_vld) begin
      addr_q <= tgt_ad;
      txn_q  <= txn_d;
    end else if (tgt_addr_inc) begin
      addr_q <= addr_q + 32'd4;
    end
  end

  assign dec_rd     = tgt_addr_vld & cls.rd;
  assign dec_wr     = tgt_addr_vld & cls.wr;
  assign dec_hit    = tgt_addr_vld & bar_hit;
  assign burst_addr = addr_q;
  assign usr_wr_stb = tgt_addr_inc & (txn_q == TX_USR_WR);
  assign cfg_wr_stb = tgt_addr_inc & (txn_q == TX_CFG_WR);

  pcitd_cfg_space #(
    .NUM_BARS      (NUM_BARS),
    .BAR_SIZE_LOG2 (BAR_SIZE_LOG2),
    .BAR_IO_MASK   (BAR_IO_MASK)
  ) u_cfg (
    .clk            (clk),
    .rst            (rst),
    .wr_stb         (cfg_wr_stb),
    .idx            (addr_q[7:2]),
    .wr_data        (tgt_ad),
    .wr_be_n        (tgt_cbe),
    .ev_par_err     (ev_par_err),
    .ev_sys_err     (ev_sys_err),
    .ev_mst_par_err (ev_mst_par_err),
    .rd_data        (cfg_rd_data),
    .io_en          (io_en),
    .mem_en         (mem_en),
    .special_en     (ctl_special_en),
    .mwi_en         (ctl_mwi_en),
    .par_resp       (ctl_par_resp),
    .serr_en        (ctl_serr_en),
    .lat_timer      (ctl_lat_timer),
    .cache_line     (ctl_cache_line),
    .bars           (bars)
  );

  // R1: the address seen in the address cycle is what the counter holds next
  a_r1_addr_capture: assert property (@(posedge clk) disable iff (rst)
    tgt_addr_vld |=> (burst_addr == $past(tgt_ad)));
  // R2: an increment without a new address steps by one dword
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (tgt_addr_inc && !tgt_addr_vld) |=> (burst_addr == $past(burst_addr) + 32'd4));
  // R5: a dword is never strobed into both destinations
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({usr_wr_stb, cfg_wr_stb}));
  // R3: a hit always comes with a read or write intent from the decoder
  a_r3_hit_has_intent: assert property (@(posedge clk) disable iff (rst)
    dec_hit |-> (dec_rd || dec_wr));

endmodule

// File: tb/pci_tgt_cfg_decode_tb.sv
module pci_tgt_cfg_decode_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tgt_ad = '0;
  logic [3:0]  tgt_cbe = 4'hF;
  logic        tgt_addr_vld = 1'b0, tgt_addr_inc = 1'b0, tgt_idsel = 1'b0;
  logic        ev_par_err = 1'b0, ev_sys_err = 1'b0, ev_mst_par_err = 1'b0;
  logic        dec_rd, dec_wr, dec_hit, usr_wr_stb, cfg_wr_stb;
  logic [31:0] burst_addr, cfg_rd_data;
  logic        ctl_special_en, ctl_mwi_en, ctl_par_resp, ctl_serr_en;
  logic [7:0]  ctl_lat_timer;
  logic [5:0]  ctl_cache_line;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pci_tgt_cfg_decode u_dut (
    .clk(clk), .rst(rst), .tgt_ad(tgt_ad), .tgt_cbe(tgt_cbe),
    .tgt_addr_vld(tgt_addr_vld), .tgt_addr_inc(tgt_addr_inc), .tgt_idsel(tgt_idsel),
    .ev_par_err(ev_par_err), .ev_sys_err(ev_sys_err), .ev_mst_par_err(ev_mst_par_err),
    .dec_rd(dec_rd), .dec_wr(dec_wr), .dec_hit(dec_hit), .burst_addr(burst_addr),
    .usr_wr_stb(usr_wr_stb), .cfg_wr_stb(cfg_wr_stb), .cfg_rd_data(cfg_rd_data),
    .ctl_special_en(ctl_special_en), .ctl_mwi_en(ctl_mwi_en), .ctl_par_resp(ctl_par_resp),
    .ctl_serr_en(ctl_serr_en), .ctl_lat_timer(ctl_lat_timer), .ctl_cache_line(ctl_cache_line)
  );

  // reference model state
  logic [31:0] m_addr = '0;
  int          m_kind = 0;   // 0 none, 1 user read, 2 user write, 3 cfg read, 4 cfg write
  logic [8:0]  m_cmd = '0;
  logic [2:0]  m_stat = '0;  // {15,14,8}
  logic [5:0]  m_cls = '0;
  logic [7:0]  m_lat = '0;
  logic [31:0] m_bar0 = '0, m_bar1 = '0;

  localparam logic [31:0] MASK0 = 32'hFFFF_F000;
  localparam logic [31:0] MASK1 = 32'hFFFF_FFE0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_rd(logic [3:0] c);
    return c inside {4'b0010, 4'b0110, 4'b1100, 4'b1110};
  endfunction
  function automatic bit is_wr(logic [3:0] c);
    return c inside {4'b0011, 4'b0111, 4'b1111};
  endfunction
  function automatic bit is_io(logic [3:0] c);
    return c inside {4'b0010, 4'b0011};
  endfunction
  function automatic bit m_hit(logic [31:0] a, logic [3:0] c);
    bit mh, ih;
    mh = ((a & MASK0) == m_bar0) && m_cmd[1] && (is_rd(c) || is_wr(c)) && !is_io(c);
    ih = ((a & MASK1) == m_bar1) && m_cmd[0] && is_io(c);
    return mh || ih;
  endfunction
  function automatic logic [31:0] m_read(logic [5:0] i);
    logic [31:0] v;
    v = '0;
    case (i)
      6'd1: begin
        v[8:0] = m_cmd;
        v[31] = m_stat[2]; v[30] = m_stat[1]; v[24] = m_stat[0];
      end
      6'd3: v = {16'd0, m_lat, m_cls, 2'b00};
      6'd4: v = m_bar0;
      6'd5: v = m_bar1 | 32'd1;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic step();
    bit e_usr, e_cfg, e_hit;
    logic [5:0] wi;
    logic [31:0] d;
    #2;
    e_hit = tgt_addr_vld && m_hit(tgt_ad, tgt_cbe);
    e_usr = tgt_addr_inc && (m_kind == 2);
    e_cfg = tgt_addr_inc && (m_kind == 4);
    chk("R1 R2 burst_addr", burst_addr, m_addr);
    chk("R4 dec_rd", {31'd0, dec_rd}, {31'd0, tgt_addr_vld && is_rd(tgt_cbe)});
    chk("R4 dec_wr", {31'd0, dec_wr}, {31'd0, tgt_addr_vld && is_wr(tgt_cbe)});
    chk("R3 dec_hit", {31'd0, dec_hit}, {31'd0, e_hit});
    chk("R5 usr_wr_stb", {31'd0, usr_wr_stb}, {31'd0, e_usr});
    chk("R5 cfg_wr_stb", {31'd0, cfg_wr_stb}, {31'd0, e_cfg});
    chk("R6 cfg_rd_data", cfg_rd_data, m_read(m_addr[7:2]));
    chk("R7 control bits", {28'd0, ctl_special_en, ctl_mwi_en, ctl_par_resp, ctl_serr_en},
        {28'd0, m_cmd[3], m_cmd[4], m_cmd[6], m_cmd[8]});
    chk("R10 latency/cache", {18'd0, ctl_lat_timer, ctl_cache_line}, {18'd0, m_lat, m_cls});
    // next state
    wi = m_addr[7:2];
    d  = tgt_ad;
    if (e_cfg) begin
      if (wi == 6'd1) begin
        if (!tgt_cbe[0]) m_cmd[7:0] = d[7:0] & 8'b0101_1011;
        if (!tgt_cbe[1]) m_cmd[8] = d[8];
        if (!tgt_cbe[3]) m_stat = m_stat & ~{d[31], d[30], d[24]};
      end else if (wi == 6'd3) begin
        if (!tgt_cbe[0]) m_cls = d[7:2];
        if (!tgt_cbe[1]) m_lat = d[15:8];
      end else if (wi == 6'd4 || wi == 6'd5) begin
        for (int b = 0; b < 4; b++) begin
          if (!tgt_cbe[b]) begin
            if (wi == 6'd4) m_bar0[b*8 +: 8] = d[b*8 +: 8] & MASK0[b*8 +: 8];
            else            m_bar1[b*8 +: 8] = d[b*8 +: 8] & MASK1[b*8 +: 8];
          end
        end
      end
    end
    m_stat = m_stat | {ev_par_err, ev_sys_err, ev_mst_par_err};
    if (tgt_addr_vld) begin
      if (tgt_cbe == 4'b1010 && tgt_idsel)      m_kind = 3;
      else if (tgt_cbe == 4'b1011 && tgt_idsel) m_kind = 4;
      else if (e_hit && is_rd(tgt_cbe))         m_kind = 1;
      else if (e_hit && is_wr(tgt_cbe))         m_kind = 2;
      else                                      m_kind = 0;
      m_addr = tgt_ad;
    end else if (tgt_addr_inc) begin
      m_addr = m_addr + 32'd4;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cyc(input bit vld, input bit inc, input logic [31:0] ad, input logic [3:0] cbe,
                     input bit idsel = 1'b0, input bit pe = 1'b0, input bit se = 1'b0,
                     input bit me = 1'b0);
    tgt_addr_vld = vld; tgt_addr_inc = inc; tgt_ad = ad; tgt_cbe = cbe; tgt_idsel = idsel;
    ev_par_err = pe; ev_sys_err = se; ev_mst_par_err = me;
    step();
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 32'd0, 4'hF);
  endtask

  task automatic wr_cfg(input logic [5:0] i, input logic [31:0] d, input logic [3:0] be_n,
                        input bit sel = 1'b1);
    cyc(1'b1, 1'b0, {24'd0, i, 2'b00}, 4'b1011, sel);
    cyc(1'b0, 1'b1, d, be_n);
  endtask

  task automatic rd_cfg(input logic [5:0] i, input logic [31:0] exp, input string req);
    cyc(1'b1, 1'b0, {24'd0, i, 2'b00}, 4'b1010, 1'b1);
    tgt_addr_vld = 1'b0; tgt_addr_inc = 1'b0; tgt_ad = '0; tgt_cbe = 4'hF; tgt_idsel = 1'b0;
    ev_par_err = 1'b0; ev_sys_err = 1'b0; ev_mst_par_err = 1'b0;
    #1;
    chk(req, cfg_rd_data, exp);
    step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    #1;
    chk("R13 burst_addr reset", burst_addr, 32'd0);
    chk("R13 lat/cache reset", {24'd0, ctl_lat_timer}, 32'd0);
    step();
    rd_cfg(6'd1, 32'd0, "R13 cmd/status reset");

    // R3 before enabling: memory access to 0 misses
    cyc(1'b1, 1'b0, 32'h0000_0000, 4'b0110);
    idle();

    // R11 size mask readback
    wr_cfg(6'd4, 32'hFFFF_FFFF, 4'b0000);
    rd_cfg(6'd4, 32'hFFFF_F000, "R11 BAR0 mask");
    wr_cfg(6'd5, 32'hFFFF_FFFF, 4'b0000);
    rd_cfg(6'd5, 32'hFFFF_FFE1, "R11 BAR1 mask");
    wr_cfg(6'd4, 32'h8000_0ABC, 4'b0000);
    wr_cfg(6'd5, 32'h0000_1007, 4'b0000);
    rd_cfg(6'd5, 32'h0000_1001, "R11 BAR1 value");

    // R7 command register
    wr_cfg(6'd1, 32'h0000_FFFF, 4'b1100);
    rd_cfg(6'd1, 32'h0000_015B, "R7 command stored bits");

    // R12 partial byte enables and R10
    wr_cfg(6'd3, 32'hAABB_CCDF, 4'b1101);
    rd_cfg(6'd3, 32'h0000_CC00, "R12 only byte1 written");
    wr_cfg(6'd3, 32'h0000_00DF, 4'b1110);
    rd_cfg(6'd3, 32'h0000_CCDC, "R10 cache line low bits");

    // R5 memory write burst with strobes
    cyc(1'b1, 1'b0, 32'h8000_0010, 4'b0111);
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 32'h1111_0000 + k, 4'b0000);
    idle();
    chk("R2 burst end address", burst_addr, 32'h8000_001C);
    // MWI write and an idle gap between data
    cyc(1'b1, 1'b0, 32'h8000_0800, 4'b1111);
    cyc(1'b0, 1'b1, 32'h2, 4'b0000);
    idle();
    cyc(1'b0, 1'b1, 32'h3, 4'b0000);

    // R3 R4 memory read variants and window boundary
    cyc(1'b1, 1'b0, 32'h8000_0FFC, 4'b0110);
    cyc(1'b0, 1'b1, 32'h0, 4'b0000);
    cyc(1'b1, 1'b0, 32'h8000_1000, 4'b0110);
    cyc(1'b1, 1'b0, 32'h8000_0000, 4'b1100);
    cyc(1'b1, 1'b0, 32'h8000_0004, 4'b1110);
    cyc(1'b1, 1'b0, 32'h8000_0004, 4'b0001);
    // write that misses: increments must not strobe
    cyc(1'b1, 1'b0, 32'h9000_0000, 4'b0111);
    cyc(1'b0, 1'b1, 32'h5, 4'b0000);

    // I/O window
    cyc(1'b1, 1'b0, 32'h0000_1000, 4'b0010);
    cyc(1'b1, 1'b0, 32'h0000_101F, 4'b0011);
    cyc(1'b0, 1'b1, 32'h6, 4'b0000);
    cyc(1'b1, 1'b0, 32'h0000_1020, 4'b0011);
    cyc(1'b1, 1'b0, 32'h0000_1004, 4'b0110);

    // config without select is ignored
    wr_cfg(6'd3, 32'h0000_FF00, 4'b0000, 1'b0);
    rd_cfg(6'd3, 32'h0000_CCDC, "R5 config write without select ignored");

    // R6 unimplemented indices
    rd_cfg(6'd0, 32'd0, "R6 index 0 reads zero");
    rd_cfg(6'd2, 32'd0, "R6 index 2 reads zero");
    rd_cfg(6'd6, 32'd0, "R6 index 6 reads zero");

    // R8 error pulses
    cyc(1'b0, 1'b0, 32'd0, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 32'd0, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 32'd0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1);
    rd_cfg(6'd1, 32'hC100_015B, "R8 status bits set");
    // R9 clear bit15 only
    wr_cfg(6'd1, 32'h8000_0000, 4'b0111);
    rd_cfg(6'd1, 32'h4100_015B, "R9 clear one status bit");
    // R9 set wins over clear in the same cycle
    cyc(1'b1, 1'b0, 32'h0000_0004, 4'b1011, 1'b1);
    cyc(1'b0, 1'b1, 32'h4100_0000, 4'b0111, 1'b0, 1'b0, 1'b1, 1'b0);
    rd_cfg(6'd1, 32'h4000_015B, "R9 set beats clear");

    // disable memory space: memory hit must vanish, I/O stays
    wr_cfg(6'd1, 32'h0000_0001, 4'b1100);
    cyc(1'b1, 1'b0, 32'h8000_0010, 4'b0111);
    chk("R3 memory disabled no strobe state", burst_addr, 32'h8000_0010);
    cyc(1'b0, 1'b1, 32'h7, 4'b0000);
    cyc(1'b1, 1'b0, 32'h0000_1008, 4'b0010);

    // reset mid-run clears everything
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_addr = '0; m_kind = 0; m_cmd = '0; m_stat = '0; m_cls = '0; m_lat = '0;
    m_bar0 = '0; m_bar1 = '0;
    #1;
    chk("R13 burst_addr after reset", burst_addr, 32'd0);
    step();
    rd_cfg(6'd4, 32'd0, "R13 BAR0 after reset");
    idle();

    finish_run();
  end

endmodule